// File: doc/BRIEF.md
# Audio ring buffer fetch engine

This block streams audio samples out of a circular region of memory into a small local FIFO. The FIFO feeds a serial audio transmitter. Software sets three byte addresses through a small register port: where the region begins, the last 64-bit word of the region, and the current fetch position. It then enables the fetch side, the FIFO and the drain side separately. While fetching is enabled, the engine issues one fixed 128-byte burst (16 words of 64 bits) at a time on a simple request/grant/response read port. After each burst it advances the fetch position. The position returns to the region start once the burst holding the last word has been fetched.

An init control bit holds the fetch position at the start address and keeps the FIFO empty. Software sets the bit and then clears it before starting playback. A soft-reset strobe clears every control bit, empties the FIFO and throws away the rest of any burst in flight, while leaving the pointers as they were. The region size is expected to be a whole number of 128-byte bursts. The fetch position can be read back, so software can track playback progress.

Top module: `audio_ring_fetch`

## Requirements
- R1: After reset, all control bits, the start, end and fetch pointers, and the FIFO level are zero, and neither `mem_req_o` nor `smp_valid_o` is asserted.
- R2: Register word addresses are: 0 start pointer, 1 end pointer, 2 fetch pointer, 3 control, 4 soft reset. The three pointers drop their low 3 address bits on write and read back with those bits as zero.
- R3: While control bit 3 (init) is 1, the fetch pointer is loaded from the start pointer, no request is issued and the FIFO is emptied.
- R4: A burst request is raised only when all of the following hold: control bit 0 (fill) is 1, control bit 2 (FIFO enable) is 1, init is 0, no burst is outstanding, and the FIFO has room for 16 words.
- R5: Each request carries the current fetch pointer as its address. When the request is granted, the pointer advances by 128 bytes.
- R6: When the last word of the granted burst (address + 120) is at or beyond the end pointer, the fetch pointer returns to the start pointer instead of advancing.
- R7: The 16 response beats of a burst are written into the FIFO in arrival order, and `fifo_level_o` rises by one for each beat.
- R8: `smp_valid_o` is 1 only when control bit 1 (drain) and the FIFO enable are both set and the FIFO holds at least one word. Words leave in FIFO order on `smp_valid_o && smp_ready_i`.
- R9: While the FIFO enable is 0, the FIFO is held empty and beats of a burst that is still in flight are dropped.
- R10: A write to the soft-reset address clears all control bits and empties the FIFO. It discards the remaining beats of any outstanding burst and leaves the pointers unchanged.
- R11: At most one burst is outstanding. No new request is raised until all 16 beats of the previous grant have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| mem_req_o | output | 1 | Burst read request |
| mem_addr_o | output | ADDR_W | Byte address of the burst's first word |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Response beat valid |
| mem_rdata_i | input | DATA_W | Response beat data |
| smp_valid_o | output | 1 | Sample word available to the serializer |
| smp_ready_i | input | 1 | Serializer takes the word |
| smp_data_o | output | DATA_W | Oldest FIFO word |
| fifo_level_o | output | LVL_W | Words held in the FIFO |

## Verification
A register write is visible on readback after the clock edge that captures it. The fetch pointer reaches the start address on the second edge after init is written. A response beat shows up in `fifo_level_o` one edge after the bench's memory model presents it. An enable-off flush or a soft reset shows up one edge after it takes effect. The bench drives all inputs on falling edges and reads results on later falling edges, after it has waited for the required edges. Request addresses and popped data are compared on every cycle against an arithmetic model of the wrapping address sequence. That model is run over several region lengths, start offsets, and memory and serializer stall patterns.

// File: rtl/arf_pkg.sv
package arf_pkg;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_START = 3'd0;
  localparam logic [REG_AW-1:0] REG_END   = 3'd1;
  localparam logic [REG_AW-1:0] REG_RPTR  = 3'd2;
  localparam logic [REG_AW-1:0] REG_CTRL  = 3'd3;
  localparam logic [REG_AW-1:0] REG_SRST  = 3'd4;

  typedef struct packed {
    logic init;      // bit 3
    logic fifo_en;   // bit 2
    logic drain_en;  // bit 1
    logic fill_en;   // bit 0
  } ctrl_t;

  typedef enum logic {
    FS_IDLE,
    FS_BEATS
  } fetch_state_e;
endpackage

// File: rtl/arf_regs.sv
module arf_regs
  import arf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [ADDR_W-1:0] rptr_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o,
  output ctrl_t             ctrl_o,
  output logic              rptr_wr_o,
  output logic [ADDR_W-1:0] rptr_wdata_o,
  output logic              srst_o,
  output logic [31:0]       rdata_o
);
  logic [ADDR_W-1:0] aligned_wdata;
  logic [ADDR_W-1:0] start_q, end_q;
  ctrl_t             ctrl_q;

  assign aligned_wdata = {wdata_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign srst_o        = wr_i && (addr_i == REG_SRST);
  assign rptr_wr_o     = wr_i && (addr_i == REG_RPTR);
  assign rptr_wdata_o  = aligned_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_i && addr_i == REG_START) start_q <= aligned_wdata;
      if (wr_i && addr_i == REG_END)   end_q   <= aligned_wdata;
      if (srst_o)                      ctrl_q  <= '0;
      else if (wr_i && addr_i == REG_CTRL) ctrl_q <= ctrl_t'(wdata_i[3:0]);
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_START: rdata_o = 32'(start_q);
      REG_END:   rdata_o = 32'(end_q);
      REG_RPTR:  rdata_o = 32'(rptr_i);
      REG_CTRL:  rdata_o = {28'd0, ctrl_q};
      default:   rdata_o = '0;
    endcase
  end

  assign start_o = start_q;
  assign end_o   = end_q;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/arf_fifo.sv
module arf_fifo #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [LVL_W-1:0]  free_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q;
  logic              do_push, do_pop;

  assign do_push = push_i && (level_q != LVL_W'(DEPTH));
  assign do_pop  = pop_i && (level_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign pop_data_o = mem_q[rd_ptr_q];
  assign level_o    = level_q;
  assign free_o     = LVL_W'(DEPTH) - level_q;
endmodule

// File: rtl/arf_fetch.sv
module arf_fetch
  import arf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned BURST_LEN = 16,
  parameter int unsigned LVL_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic              fill_en_i,
  input  logic              fifo_en_i,
  input  logic              init_i,
  input  logic              srst_i,
  input  logic              rptr_wr_i,
  input  logic [ADDR_W-1:0] rptr_wdata_i,
  input  logic [LVL_W-1:0]  free_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] rptr_o
);
  localparam int unsigned WORD_BYTES  = DATA_W / 8;
  localparam int unsigned BURST_BYTES = BURST_LEN * WORD_BYTES;
  localparam int unsigned CNT_W       = $clog2(BURST_LEN);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BURST_BYTES);
  localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(BURST_BYTES - WORD_BYTES);

  fetch_state_e      state_q;
  logic [CNT_W-1:0]  beat_q;
  logic              discard_q;
  logic [ADDR_W-1:0] rptr_q;
  logic              accept, wraps, drop_now, last_beat;

  assign mem_req_o  = (state_q == FS_IDLE) && fill_en_i && fifo_en_i && !init_i &&
                      !srst_i && (free_i >= LVL_W'(BURST_LEN));
  assign mem_addr_o = rptr_q;
  assign accept     = mem_req_o && mem_gnt_i;
  assign wraps      = (rptr_q + LAST_OFS) >= end_i;
  assign drop_now   = srst_i || init_i || !fifo_en_i;
  assign last_beat  = mem_rvalid_i && (beat_q == CNT_W'(BURST_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
    end else if (init_i) begin
      rptr_q <= start_i;
    end else if (rptr_wr_i) begin
      rptr_q <= rptr_wdata_i;
    end else if (accept) begin
      rptr_q <= wraps ? start_i : rptr_q + STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FS_IDLE;
      beat_q    <= '0;
      discard_q <= 1'b0;
    end else begin
      unique case (state_q)
        FS_IDLE: begin
          if (accept) begin
            state_q   <= FS_BEATS;
            beat_q    <= '0;
            discard_q <= 1'b0;
          end
        end
        FS_BEATS: begin
          if (drop_now) discard_q <= 1'b1;
          if (mem_rvalid_i) beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= FS_IDLE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign push_o = (state_q == FS_BEATS) && mem_rvalid_i && !discard_q && !drop_now;
  assign rptr_o = rptr_q;
endmodule

// File: rtl/audio_ring_fetch.sv
module audio_ring_fetch
  import arf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned BURST_LEN  = 16,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [DATA_W-1:0] smp_data_o,
  output logic [LVL_W-1:0]  fifo_level_o
);
  localparam int unsigned OFS_W = $clog2(DATA_W / 8);

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] start_addr, end_addr, rptr, rptr_wdata;
  logic              rptr_wr, srst, push, flush, pop;
  logic [LVL_W-1:0]  level, free;

  arf_regs #(
    .ADDR_W(ADDR_W),
    .OFS_W (OFS_W)
  ) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rptr_i      (rptr),
    .start_o     (start_addr),
    .end_o       (end_addr),
    .ctrl_o      (ctrl),
    .rptr_wr_o   (rptr_wr),
    .rptr_wdata_o(rptr_wdata),
    .srst_o      (srst),
    .rdata_o     (reg_rdata_o)
  );

  arf_fetch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BURST_LEN(BURST_LEN),
    .LVL_W    (LVL_W)
  ) i_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_addr),
    .end_i       (end_addr),
    .fill_en_i   (ctrl.fill_en),
    .fifo_en_i   (ctrl.fifo_en),
    .init_i      (ctrl.init),
    .srst_i      (srst),
    .rptr_wr_i   (rptr_wr),
    .rptr_wdata_i(rptr_wdata),
    .free_i      (free),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i),
    .push_o      (push),
    .rptr_o      (rptr)
  );

  assign flush = !ctrl.fifo_en || ctrl.init || srst;

  arf_fifo #(
    .DATA_W(DATA_W),
    .DEPTH (FIFO_DEPTH),
    .LVL_W (LVL_W)
  ) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .push_i     (push),
    .push_data_i(mem_rdata_i),
    .pop_i      (pop),
    .pop_data_o (smp_data_o),
    .level_o    (level),
    .free_o     (free)
  );

  assign smp_valid_o  = ctrl.drain_en && ctrl.fifo_en && (level != '0);
  assign pop          = smp_valid_o && smp_ready_i;
  assign fifo_level_o = level;
endmodule

// File: rtl/arf_checker.sv
module arf_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned BURST_LEN  = 16,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned LVL_W      = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              mem_req_i,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_rvalid_i,
  input logic [ADDR_W-1:0] rptr_i,
  input logic [ADDR_W-1:0] start_i,
  input logic              fill_en_i,
  input logic              drain_en_i,
  input logic              fifo_en_i,
  input logic              init_i,
  input logic              smp_valid_i,
  input logic [LVL_W-1:0]  level_i
);
  localparam int unsigned OUT_W = $clog2(BURST_LEN + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_LEN * (DATA_W / 8));

  logic [OUT_W-1:0] outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else if (mem_req_i && mem_gnt_i) outst_q <= OUT_W'(BURST_LEN);
    else if (mem_rvalid_i && outst_q != '0) outst_q <= outst_q - 1'b1;
  end

  assert_req_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> (fill_en_i && fifo_en_i && !init_i &&
                   level_i <= LVL_W'(FIFO_DEPTH - BURST_LEN)));

  assert_one_burst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> (outst_q == '0));

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_gnt_i && !reg_wr_i) |=>
      ((rptr_i == $past(mem_addr_i) + STEP) || (rptr_i == start_i)));

  assert_init_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && $past(init_i) && $stable(start_i)) |-> (rptr_i == start_i && !mem_req_i));

  assert_level_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LVL_W'(FIFO_DEPTH));

  assert_valid_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |-> (drain_en_i && fifo_en_i && level_i != '0));

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !$past(fifo_en_i)) |-> (level_i == '0));
endmodule

bind audio_ring_fetch arf_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BURST_LEN (BURST_LEN),
  .FIFO_DEPTH(FIFO_DEPTH),
  .LVL_W     (LVL_W)
) i_arf_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .mem_req_i   (mem_req_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_i  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .rptr_i      (rptr),
  .start_i     (start_addr),
  .fill_en_i   (ctrl.fill_en),
  .drain_en_i  (ctrl.drain_en),
  .fifo_en_i   (ctrl.fifo_en),
  .init_i      (ctrl.init),
  .smp_valid_i (smp_valid_o),
  .level_i     (fifo_level_o)
);

// File: tb/test_audio_ring_fetch.sv
module test_audio_ring_fetch;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned LVL_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mem_req, mem_gnt, mem_rvalid;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic              smp_valid;
  logic              smp_ready = 1'b0;
  logic [DATA_W-1:0] smp_data;
  logic [LVL_W-1:0]  level;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int grants = 0;
  int popped = 0;
  int pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  logic stall = 1'b0;
  logic chk_on = 1'b0;
  logic [31:0] exp_start = '0, exp_end = '0, exp_fetch = '0, exp_rd = '0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  audio_ring_fetch i_audio_ring_fetch (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .smp_valid_o(smp_valid), .smp_ready_i(smp_ready), .smp_data_o(smp_data),
    .fifo_level_o(level)
  );

  function automatic logic [63:0] word_of(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  assign mem_gnt = mem_req;

  // memory model: beats start the cycle after the grant
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt   <= 0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else if (mem_req && mem_gnt) begin
      pend_cnt   <= 16;
      pend_addr  <= mem_addr;
      mem_rvalid <= 1'b0;
    end else if (pend_cnt != 0 && (!stall || (cyc % 3) != 2)) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= word_of(pend_addr);
      pend_addr  <= pend_addr + 32'd8;
      pend_cnt   <= pend_cnt - 1;
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  // sink and fetch monitor, sampled at the falling edge
  always @(negedge clk) begin
    cyc++;
    smp_ready = chk_on && ((cyc % 5) != 0);
    if (smp_valid && smp_ready) begin
      chk("R7 R8 sample order", smp_data, word_of(exp_rd));
      exp_rd = (exp_rd == exp_end) ? exp_start : exp_rd + 32'd8;
      popped++;
    end
    if (mem_req && rst_n) begin
      chk("R5 R6 fetch address", 64'(mem_addr), 64'(exp_fetch));
      chk("R11 single outstanding burst", 64'(pend_cnt), 64'd0);
      exp_fetch = (exp_fetch + 32'd120 >= exp_end) ? exp_start : exp_fetch + 32'd128;
      grants++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle_beats();
    while (pend_cnt != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic model_reset(input logic [31:0] s, input logic [31:0] e);
    exp_start = s; exp_end = e; exp_fetch = s; exp_rd = s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int g0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level after reset", 64'(level), 0);
    chk("R1 request after reset", 64'(mem_req), 0);
    chk("R1 valid after reset", 64'(smp_valid), 0);
    for (int a = 0; a < 4; a++) begin
      rdreg(3'(a), rd);
      chk("R1 register after reset", 64'(rd), 0);
    end

    // R2: alignment of pointer writes
    wr(3'd0, 32'h0000_1003); rdreg(3'd0, rd); chk("R2 start aligned", 64'(rd), 64'h1000);
    wr(3'd1, 32'h0000_117F); rdreg(3'd1, rd); chk("R2 end aligned", 64'(rd), 64'h1178);
    wr(3'd2, 32'h0000_2225); rdreg(3'd2, rd); chk("R2 fetch ptr aligned", 64'(rd), 64'h2220);

    // R3: init reloads pointer
    wr(3'd3, 32'h8);
    repeat (2) @(negedge clk);
    rdreg(3'd2, rd); chk("R3 init loads start", 64'(rd), 64'h1000);
    chk("R3 no request during init", 64'(mem_req), 0);
    rdreg(3'd3, rd); chk("R2 ctrl readback", 64'(rd), 64'h8);

    // R4: fill only, no drain: FIFO fills to two bursts and stops
    model_reset(32'h1000, 32'h1178);
    wr(3'd3, 32'h5);
    while (!(grants == 2 && pend_cnt == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7 level after two bursts", 64'(level), 64'd32);
    rdreg(3'd2, rd); chk("R5 pointer after two grants", 64'(rd), 64'h1100);
    chk("R8 no valid with drain off", 64'(smp_valid), 0);
    repeat (20) @(negedge clk);
    chk("R4 no request while FIFO full", 64'(grants), 64'd2);

    // drain on: stream across several wraps
    chk_on = 1'b1;
    wr(3'd3, 32'h7);
    while (popped < 100) @(negedge clk);
    chk_on = 1'b0;
    wr(3'd3, 32'h5);
    repeat (2) @(negedge clk);
    chk("R8 valid drops with drain off", 64'(smp_valid), 0);

    // R9: FIFO enable off flushes and drops in-flight beats
    wr(3'd3, 32'h1);
    settle_beats();
    chk("R9 level after FIFO disable", 64'(level), 0);
    g0 = grants;
    repeat (20) @(negedge clk);
    chk("R4 no request with FIFO off", 64'(grants), 64'(g0));

    // R10: soft reset in the middle of a burst
    wr(3'd3, 32'h8);
    repeat (2) @(negedge clk);
    model_reset(32'h1000, 32'h1178);
    wr(3'd3, 32'h5);
    while (pend_cnt != 10) @(negedge clk);
    wr(3'd4, 32'h0);
    settle_beats();
    chk("R10 level after soft reset", 64'(level), 0);
    rdreg(3'd3, rd); chk("R10 ctrl cleared", 64'(rd), 0);
    rdreg(3'd2, rd); chk("R10 pointer kept", 64'(rd), 64'h1080);
    rdreg(3'd0, rd); chk("R10 start kept", 64'(rd), 64'h1000);

    // sweep region length, start offset and stall pattern
    for (int nb = 1; nb <= 4; nb++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] base, last;
        int target;
        base  = 32'h8000 + 32'(nb) * 32'h1000 + ((k == 0) ? 32'h0 : (k == 1) ? 32'h8 : 32'h38);
        last  = base + 32'(nb) * 32'd128 - 32'd8;
        stall = 1'((nb + k) % 2);
        wr(3'd3, 32'h8);
        wr(3'd0, base);
        wr(3'd1, last);
        repeat (2) @(negedge clk);
        rdreg(3'd2, rd); chk("R3 init reload in sweep", 64'(rd), 64'(base));
        model_reset(base, last);
        target = popped + 3 * nb * 16 + 5;
        chk_on = 1'b1;
        wr(3'd3, 32'h7);
        while (popped < target) @(negedge clk);
        chk_on = 1'b0;
        wr(3'd3, 32'h8);
        settle_beats();
        chk("R3 init empties FIFO", 64'(level), 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule